// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes written by a processor into asynchronous serial frames on a single output line. A one-entry holding buffer takes the processor's write; a separate shift register holds the frame being sent. While one frame is on the line, software can refill the buffer, so frames follow each other without a gap. Each frame is a start bit of 0, seven or eight data bits sent least significant bit first, an optional extra bit, and one or two stop bits of 1. The extra bit is even parity, odd parity or a multiprocessor flag taken from a configuration bit. Each bit lasts one period of an external bit-rate tick.

When the first stop bit begins, the sequencer looks at the buffer. If the buffer holds data, that data moves into the shift register and the next start bit follows the last stop bit directly. If the buffer is empty, the transmit-end flag rises and the line returns to the idle level of 1. Two level interrupt requests follow the buffer-empty and transmit-end flags, each gated by its own enable. The bit-rate generator and any receiver belong to other blocks.

The sequencer has six states. ST_IDLE holds the line at 1. On a tick with the buffer full it takes the buffer and moves to ST_START, which drives 0. On the next tick ST_START goes to ST_DATA, which sends one data bit per tick. After the last data bit ST_DATA goes to ST_XBIT if an extra bit is configured, and to ST_STOP1 if not. ST_XBIT always goes to ST_STOP1. Every move into ST_STOP1 is a stop entry: the buffer is taken if it is full, and transmit-end is set if it is empty. On a tick ST_STOP1 goes to ST_STOP2 when two stop bits are configured. Otherwise it goes to ST_START if a chained frame was loaded, and to ST_IDLE if not. ST_STOP2 makes the same choice between ST_START and ST_IDLE.

Top module: `utx_serial_tx`

## Requirements
- R1: Data bits follow the start bit least significant bit first. When `cfg_len7` is 1 the frame has 7 data bits (bits 6..0); when it is 0 the frame has 8 data bits.
- R2: `cfg_xmode` selects the bit that follows the data. 00 means no bit is sent. 01 means even parity: the total number of ones in the data bits and this bit is even. 10 means odd parity. 11 means the multiprocessor bit.
- R3: `cfg_two_stop` = 0 gives one stop bit of 1 and `cfg_two_stop` = 1 gives two.
- R4: Outside a frame `txd` is 1. While `tx_end` is 1, `txd` is 1.
- R5: If the buffer is full when the first stop bit begins, its data is sent as the next frame. That frame's start bit immediately follows the last stop bit, with no idle bit between them.
- R6: If the buffer is empty when the first stop bit begins, `tx_end` becomes 1 at that point and stays 1 until the next write.
- R7: `tend_irq` is 1 exactly when `tx_end` and `cfg_tend_ie` are both 1.
- R8: Moving the buffer into the shift register sets `buf_empty` to 1. `bufe_irq` is 1 exactly when `buf_empty` and `cfg_bufe_ie` are both 1.
- R9: A write (`wr_en` = 1) clears `buf_empty` and `tx_end` in the next cycle.
- R10: Each bit lasts exactly one `bit_tick` period, and `txd` changes only on a clock edge where `bit_tick` is 1. If the block is idle when a write lands, the tick after the write starts the frame, so exactly one idle bit period passes before the start bit.
- R11: The multiprocessor bit is the value of `cfg_mpb` at the moment the buffer moves into the shift register. Later changes to `cfg_mpb` do not affect the frame in flight.
- R12: After reset `txd` is 1, `buf_empty` is 1 and `tx_end` is 1. With both enables low, both interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | DATA_W | Data written to the holding buffer |
| cfg_len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_xmode | input | 2 | Extra bit: 00 none, 01 even, 10 odd, 11 multiprocessor |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_mpb | input | 1 | Multiprocessor bit value, latched at transfer |
| cfg_bufe_ie | input | 1 | Buffer-empty interrupt enable |
| cfg_tend_ie | input | 1 | Transmit-end interrupt enable |
| txd | output | 1 | Serial line |
| buf_empty | output | 1 | Holding buffer empty flag |
| tx_end | output | 1 | Transmit-end flag |
| bufe_irq | output | 1 | Buffer-empty interrupt request |
| tend_irq | output | 1 | Transmit-end interrupt request |

## Verification
The assertions assume that `bit_tick` is a single-cycle pulse with gaps of at least one idle cycle. They also assume that software writes the buffer only while `buf_empty` is 1 and leaves the frame format unchanged while a frame is on the line. The bench meets all three assumptions. It drives a tick once every four clocks and issues writes only in a cycle without a tick, after it has seen `buf_empty` high. It changes the format only between frames. The one exception is `cfg_mpb`, which the bench changes on purpose after the transfer.

// File: rtl/utx_pkg.sv
package utx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_XBIT  = 3'd3,
        ST_STOP1 = 3'd4,
        ST_STOP2 = 3'd5
    } utx_state_e;

    typedef enum logic [1:0] {
        XB_NONE = 2'b00,
        XB_EVEN = 2'b01,
        XB_ODD  = 2'b10,
        XB_MPB  = 2'b11
    } xbit_mode_e;

endpackage

// File: rtl/utx_holding_buf.sv
module utx_holding_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] data_q,
    output logic              empty_q
);

    // A write wins over a transfer in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            empty_q <= 1'b1;
        end else if (wr_en) begin
            data_q  <= wr_data;
            empty_q <= 1'b0;
        end else if (take) begin
            empty_q <= 1'b1;
        end
    end

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import utx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] load_data,
    input  logic              len_short,
    input  logic [1:0]        xmode,
    input  logic              mpb_in,
    output logic              bit_out,
    output logic              xbit_out
);

    localparam logic [DATA_W-1:0] MASK_LONG  = '1;
    localparam logic [DATA_W-1:0] MASK_SHORT = MASK_LONG >> 1;

    logic [DATA_W-1:0] shreg_q;
    logic [DATA_W-1:0] masked;
    logic              parity;
    logic              xbit_d;
    xbit_mode_e        mode;

    assign mode   = xbit_mode_e'(xmode);
    assign masked = load_data & (len_short ? MASK_SHORT : MASK_LONG);
    assign parity = ^masked;

    always_comb begin
        unique case (mode)
            XB_EVEN: xbit_d = parity;
            XB_ODD:  xbit_d = ~parity;
            XB_MPB:  xbit_d = mpb_in;
            default: xbit_d = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q  <= '0;
            xbit_out <= 1'b1;
        end else if (load) begin
            shreg_q  <= masked;
            xbit_out <= xbit_d;
        end else if (shift) begin
            shreg_q  <= shreg_q >> 1;
        end
    end

    assign bit_out = shreg_q[0];

endmodule

// File: rtl/utx_seq.sv
module utx_seq
    import utx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       wr_en,
    input  logic       buf_empty,
    input  logic       cfg_len7,
    input  logic [1:0] cfg_xmode,
    input  logic       cfg_two_stop,
    input  logic       bit_out,
    input  logic       xbit_out,
    output logic       take,
    output logic       shift,
    output logic       txd,
    output logic       tx_end
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 2);

    utx_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             chain_q, chain_d;
    logic             tend_q, tend_d;
    logic             stop_entry;
    logic [CNT_W-1:0] last_idx;
    xbit_mode_e       mode;

    assign mode     = xbit_mode_e'(cfg_xmode);
    assign last_idx = cfg_len7 ? LAST_SHORT : LAST_LONG;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            chain_q <= 1'b0;
            tend_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            chain_q <= chain_d;
            tend_q  <= tend_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        chain_d    = chain_q;
        take       = 1'b0;
        shift      = 1'b0;
        stop_entry = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (bit_tick && !buf_empty) begin
                    state_d = ST_START;
                    take    = 1'b1;
                end
            end
            ST_START: begin
                if (bit_tick) begin
                    state_d = ST_DATA;
                    cnt_d   = '0;
                end
            end
            ST_DATA: begin
                if (bit_tick) begin
                    shift = 1'b1;
                    if (cnt_q == last_idx) begin
                        if (mode == XB_NONE) begin
                            state_d    = ST_STOP1;
                            stop_entry = 1'b1;
                        end else begin
                            state_d = ST_XBIT;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_XBIT: begin
                if (bit_tick) begin
                    state_d    = ST_STOP1;
                    stop_entry = 1'b1;
                end
            end
            ST_STOP1: begin
                if (bit_tick) begin
                    if (cfg_two_stop) state_d = ST_STOP2;
                    else              state_d = chain_q ? ST_START : ST_IDLE;
                end
            end
            ST_STOP2: begin
                if (bit_tick) state_d = chain_q ? ST_START : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (stop_entry) begin
            chain_d = !buf_empty;
            take    = !buf_empty;
        end
    end

    always_comb begin
        if (wr_en)                        tend_d = 1'b0;
        else if (stop_entry && buf_empty) tend_d = 1'b1;
        else                              tend_d = tend_q;
    end

    // Output logic
    always_comb begin
        unique case (state_q)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = bit_out;
            ST_XBIT:  txd = xbit_out;
            default:  txd = 1'b1;
        endcase
    end

    assign tx_end = tend_q;

endmodule

// File: rtl/utx_serial_tx.sv
module utx_serial_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cfg_len7,
    input  logic [1:0]        cfg_xmode,
    input  logic              cfg_two_stop,
    input  logic              cfg_mpb,
    input  logic              cfg_bufe_ie,
    input  logic              cfg_tend_ie,
    output logic              txd,
    output logic              buf_empty,
    output logic              tx_end,
    output logic              bufe_irq,
    output logic              tend_irq
);

    logic [DATA_W-1:0] buf_data;
    logic              take;
    logic              shift;
    logic              bit_out;
    logic              xbit_out;

    utx_holding_buf #(.DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .data_q  (buf_data),
        .empty_q (buf_empty)
    );

    utx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take),
        .shift     (shift),
        .load_data (buf_data),
        .len_short (cfg_len7),
        .xmode     (cfg_xmode),
        .mpb_in    (cfg_mpb),
        .bit_out   (bit_out),
        .xbit_out  (xbit_out)
    );

    utx_seq #(.DATA_W(DATA_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick     (bit_tick),
        .wr_en        (wr_en),
        .buf_empty    (buf_empty),
        .cfg_len7     (cfg_len7),
        .cfg_xmode    (cfg_xmode),
        .cfg_two_stop (cfg_two_stop),
        .bit_out      (bit_out),
        .xbit_out     (xbit_out),
        .take         (take),
        .shift        (shift),
        .txd          (txd),
        .tx_end       (tx_end)
    );

    assign bufe_irq = buf_empty & cfg_bufe_ie;
    assign tend_irq = tx_end & cfg_tend_ie;

endmodule

// File: rtl/utx_checker.sv
module utx_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic wr_en,
    input logic txd,
    input logic buf_empty,
    input logic tx_end,
    input logic bufe_irq,
    input logic tend_irq
);

    // R4
    mark_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_end |-> txd);

    // R9
    write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!buf_empty && !tx_end));

    // R10
    line_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd) |-> $past(bit_tick));

    // R8
    empty_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_empty) |-> $past(bit_tick));

    // R6
    end_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_end) |-> ($past(bit_tick) && $past(buf_empty)));

    // R7
    tend_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tend_irq |-> (tx_end && txd));

    // R8
    bufe_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bufe_irq |-> buf_empty);

endmodule

bind utx_serial_tx utx_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .wr_en     (wr_en),
    .txd       (txd),
    .buf_empty (buf_empty),
    .tx_end    (tx_end),
    .bufe_irq  (bufe_irq),
    .tend_irq  (tend_irq)
);

// File: tb/test_utx_serial_tx.sv
module test_utx_serial_tx;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_tick = 1'b0;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       cfg_len7, cfg_two_stop, cfg_mpb, cfg_bufe_ie, cfg_tend_ie;
    logic [1:0] cfg_xmode;
    logic       txd, buf_empty, tx_end, bufe_irq, tend_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic log_bits [4096];
    int   log_n = 0;

    always #5 clk = ~clk;

    utx_serial_tx #(.DATA_W(8)) i_utx_serial_tx (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
        .wr_data(wr_data), .cfg_len7(cfg_len7), .cfg_xmode(cfg_xmode),
        .cfg_two_stop(cfg_two_stop), .cfg_mpb(cfg_mpb),
        .cfg_bufe_ie(cfg_bufe_ie), .cfg_tend_ie(cfg_tend_ie),
        .txd(txd), .buf_empty(buf_empty), .tx_end(tx_end),
        .bufe_irq(bufe_irq), .tend_irq(tend_irq)
    );

    // tick once every four clocks
    logic [1:0] tcnt = 2'd0;
    always @(posedge clk) begin
        tcnt     <= tcnt + 2'd1;
        bit_tick <= (tcnt == 2'd2);
    end

    // one line sample per bit period, just before the tick edge
    always @(negedge clk) begin
        if (bit_tick && log_n < 4096) begin
            log_bits[log_n] = txd;
            log_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int build(input logic [7:0] d, input bit l7, input logic [1:0] m,
                                 input bit two, input bit mpb, output logic [11:0] f);
        int len = l7 ? 7 : 8;
        int k = 0;
        logic par = 1'b0;
        f = '1;
        f[k] = 1'b0; k++;
        for (int i = 0; i < len; i++) begin
            f[k] = d[i]; par ^= d[i]; k++;
        end
        if (m == 2'b01) begin f[k] = par;  k++; end
        if (m == 2'b10) begin f[k] = ~par; k++; end
        if (m == 2'b11) begin f[k] = mpb;  k++; end
        f[k] = 1'b1; k++;
        if (two) begin f[k] = 1'b1; k++; end
        return k;
    endfunction

    task automatic parse(input int start, input int n, output int gap,
                         output int nxt, output logic [11:0] got);
        int p = start;
        gap = 0;
        got = '1;
        while (p < log_n && log_bits[p] == 1'b1) begin gap++; p++; end
        for (int i = 0; i < n; i++) got[i] = (p + i < log_n) ? log_bits[p + i] : 1'bx;
        nxt = p + n;
    endtask

    task automatic quiet_slot();
        @(negedge clk);
        while (!bit_tick) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_ticks(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            while (!bit_tick) @(negedge clk);
        end
    endtask

    task automatic one_frame(input logic [7:0] d, input bit l7, input logic [1:0] m,
                             input bit two, input bit ie);
        logic [11:0] exp_f, got;
        int n, gap, nxt;
        cfg_len7 = l7; cfg_xmode = m; cfg_two_stop = two; cfg_mpb = d[3];
        cfg_tend_ie = ie; cfg_bufe_ie = ~ie;
        n = build(d, l7, m, two, d[3], exp_f);
        quiet_slot();
        log_n = 0;
        do_write(d);
        // R9 flags cleared by the write
        chk(!buf_empty && !tx_end, "R9 write clears flags", {buf_empty, tx_end}, 0);
        chk(bufe_irq == 1'b0, "R8 bufe_irq low when full", bufe_irq, 0);
        wait_ticks(n + 2);
        parse(0, n, gap, nxt, got);
        // R10 one idle bit before the start bit
        chk(gap == 1, "R10 start latency", gap, 1);
        // R1 R2 R3 frame content
        chk(got == exp_f, "R1/R2/R3 frame bits", got, exp_f);
        chk(tx_end == 1'b1 && txd == 1'b1, "R6 end flag and R4 mark", {tx_end, txd}, 3);
        chk(tend_irq == ie, "R7 tend_irq", tend_irq, ie);
        chk(buf_empty && bufe_irq == ~ie, "R8 bufe_irq", {buf_empty, bufe_irq}, {1'b1, ~ie});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  pats [5] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h81};
        logic [11:0] ea, eb, ga, gb;
        int na, nb, gap, nxt;

        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
        cfg_len7 = 1'b0; cfg_xmode = 2'b00; cfg_two_stop = 1'b0; cfg_mpb = 1'b0;
        cfg_bufe_ie = 1'b0; cfg_tend_ie = 1'b0;
        repeat (4) @(negedge clk);
        // R12 reset state
        chk(txd && buf_empty && tx_end && !bufe_irq && !tend_irq, "R12 reset",
            {txd, buf_empty, tx_end, bufe_irq, tend_irq}, 5'b11100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(txd && buf_empty && tx_end, "R12 after release", {txd, buf_empty, tx_end}, 3'b111);

        // sweep: length x extra bit x stop count x patterns
        for (int l = 0; l < 2; l++)
            for (int m = 0; m < 4; m++)
                for (int s = 0; s < 2; s++)
                    for (int p = 0; p < 5; p++)
                        one_frame(pats[p] ^ 8'(m * 16 + s * 3), l[0], 2'(m), s[0], p[0]);

        // R5 back-to-back frames
        cfg_len7 = 1'b0; cfg_xmode = 2'b01; cfg_two_stop = 1'b1; cfg_mpb = 1'b0;
        cfg_bufe_ie = 1'b1; cfg_tend_ie = 1'b1;
        na = build(8'h3C, 1'b0, 2'b01, 1'b1, 1'b0, ea);
        nb = build(8'hC7, 1'b0, 2'b01, 1'b1, 1'b0, eb);
        quiet_slot();
        log_n = 0;
        do_write(8'h3C);
        while (!buf_empty) @(negedge clk);
        chk(bufe_irq == 1'b1, "R8 bufe_irq after transfer", bufe_irq, 1);
        @(negedge clk);
        while (bit_tick) @(negedge clk);
        do_write(8'hC7);
        chk(tx_end == 1'b0, "R9 tx_end low during chain", tx_end, 0);
        wait_ticks(na + nb + 3);
        parse(0, na, gap, nxt, ga);
        chk(ga == ea, "R5 first frame", ga, ea);
        parse(nxt, nb, gap, nxt, gb);
        chk(gap == 0, "R5 no idle bit between frames", gap, 0);
        chk(gb == eb, "R5 second frame", gb, eb);
        chk(tx_end && tend_irq, "R6 end after chain", {tx_end, tend_irq}, 3);

        // R11 multiprocessor bit latched at transfer
        for (int v = 0; v < 2; v++) begin
            cfg_len7 = 1'b1; cfg_xmode = 2'b11; cfg_two_stop = 1'b0; cfg_mpb = v[0];
            na = build(8'h55, 1'b1, 2'b11, 1'b0, v[0], ea);
            quiet_slot();
            log_n = 0;
            do_write(8'h55);
            while (!buf_empty) @(negedge clk);
            cfg_mpb = ~v[0];
            wait_ticks(na + 2);
            parse(0, na, gap, nxt, ga);
            chk(ga == ea, "R11 mpb latched", ga, ea);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule